// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block is the address and count engine of one DMA channel. A start pulse captures a channel configuration: start address, X count, signed X stride, Y count, signed Y stride, a 2D enable, interrupt options and a flow mode. From then on every element that the data path accepts moves the engine forward by one step. Along a row the address advances by the X stride and the X count falls by one. At the end of a row in 2D mode, the step uses the Y stride in place of the X stride. The block therefore never emits the address past the row end, and it needs no corrective subtraction.

When the last element of a work unit is accepted, the engine raises an optional one-cycle interrupt. It then does one of three things, chosen by the flow mode: it stops and reports completion, it restarts from the captured configuration (autobuffer), or it asks the surrounding channel for its next descriptor and waits for the next start pulse. Descriptor fetch and the data path sit outside the block.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, run, done, irq and desc_req are low, and the current address and both current counts are zero.
- R2: A start pulse takes effect at the next clock edge. It loads the current address from the start address and the current counts from the configured counts (a configured count of zero loads all ones), sets run and clears done. Start takes priority over an element accepted in the same cycle.
- R3: An accepted element that is not the last of its row adds the sign-extended X stride to the current address and decrements the current X count. The new values are visible after the same clock edge.
- R4: elem_ack is ignored while run is low, and also while the current X count is zero. Address and counts stay unchanged.
- R5: In 2D mode, accepting the last element of a row while the current Y count is above one does three things: it decrements the Y count, reloads the X count from the captured X count, and sets the address to the current address plus the Y stride.
- R6: When the interrupt enable is set, the element that ends a work unit produces a one-cycle irq pulse in the cycle after its clock edge.
- R7: When both the interrupt enable and the row interrupt option are set in 2D mode, every row change also produces a one-cycle irq pulse.
- R8: The end of a work unit in stop mode (flow 2'b00, and also the unused code 2'b11) clears run, sets done, advances the address by the X stride and leaves the X count at zero.
- R9: The end of a work unit in autobuffer mode (flow 2'b01) reloads the address and counts from the captured configuration and keeps run set.
- R10: The end of a work unit in descriptor mode (flow 2'b10) pulses desc_req for one cycle, keeps run set, advances the address by the X stride and leaves the X count at zero. Further elements are then ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture configuration and begin a work unit |
| cfg_start_addr_i | input | ADDR_W | Start address |
| cfg_x_count_i | input | CNT_W | Elements per row (0 means all ones) |
| cfg_x_mod_i | input | CNT_W | Signed X stride in bytes |
| cfg_y_count_i | input | CNT_W | Rows per work unit (0 means all ones) |
| cfg_y_mod_i | input | CNT_W | Signed Y stride in bytes |
| cfg_2d_i | input | 1 | Enable 2D operation |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| cfg_row_irq_i | input | 1 | Interrupt on every row in 2D mode |
| cfg_flow_i | input | 2 | 00 stop, 01 autobuffer, 10 descriptor, 11 stop |
| elem_ack_i | input | 1 | Data path accepted the element at cur_addr_o |
| cur_addr_o | output | ADDR_W | Current element address |
| cur_x_o | output | CNT_W | Remaining elements in current row |
| cur_y_o | output | CNT_W | Remaining rows |
| run_o | output | 1 | Channel running |
| done_o | output | 1 | Work unit completed in stop mode |
| irq_o | output | 1 | One-cycle interrupt pulse |
| desc_req_o | output | 1 | One-cycle request for the next descriptor |

## Verification
The hardest case to reach is the order of events at the final row boundary of a 2D work unit in autobuffer mode with row interrupts enabled. In that one accepted element, the row-change branch must yield to the unit-end branch: the reload must win, and only a single irq pulse may appear. The stimulus gets there by running a small 3x3 unit through to its end and then continuing into the reloaded unit. It inserts idle cycles between elements so that each irq pulse is seen in isolation. A negative X stride in descriptor mode, followed by acks that must be ignored, covers the sign extension and the wait-for-start state.

// File: rtl/dma2d_pkg.sv
// Shared encodings for the 2D DMA address generator.
package dma2d_pkg;
    // Flow modes selecting what happens at the end of a work unit.
    typedef enum logic [1:0] {
        FLOW_STOP = 2'b00,
        FLOW_AUTO = 2'b01,
        FLOW_DESC = 2'b10,
        FLOW_RSVD = 2'b11
    } flow_e;
endpackage

// File: rtl/dma2d_cfg_latch.sv
// Holds the channel configuration captured by a start pulse.
// Assumes the configuration inputs are valid in the cycle start is high.
module dma2d_cfg_latch #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  x_count_i,
    input  logic [CNT_W-1:0]  x_mod_i,
    input  logic [CNT_W-1:0]  y_count_i,
    input  logic [CNT_W-1:0]  y_mod_i,
    input  logic              two_d_i,
    input  logic              irq_en_i,
    input  logic              row_irq_i,
    input  logic [1:0]        flow_i,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic [CNT_W-1:0]  x_count_o,
    output logic [CNT_W-1:0]  x_mod_o,
    output logic [CNT_W-1:0]  y_count_o,
    output logic [CNT_W-1:0]  y_mod_o,
    output logic              two_d_o,
    output logic              irq_en_o,
    output logic              row_irq_o,
    output logic [1:0]        flow_o
);
    // Capture every configuration field on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr_o <= '0;
            x_count_o    <= '0;
            x_mod_o      <= '0;
            y_count_o    <= '0;
            y_mod_o      <= '0;
            two_d_o      <= 1'b0;
            irq_en_o     <= 1'b0;
            row_irq_o    <= 1'b0;
            flow_o       <= 2'b00;
        end else if (capture_i) begin
            start_addr_o <= start_addr_i;
            x_count_o    <= x_count_i;
            x_mod_o      <= x_mod_i;
            y_count_o    <= y_count_i;
            y_mod_o      <= y_mod_i;
            two_d_o      <= two_d_i;
            irq_en_o     <= irq_en_i;
            row_irq_o    <= row_irq_i;
            flow_o       <= flow_i;
        end
    end
endmodule

// File: rtl/dma2d_count_unit.sv
// X and Y element counters. Flags a row change and the end of a work unit
// for the accepted element. Assumes step_i is only high when the X count
// is non-zero; load_i has priority over step_i.
module dma2d_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] ld_x_i,
    input  logic [CNT_W-1:0] ld_y_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] row_x_i,
    input  logic             two_d_i,
    output logic [CNT_W-1:0] cur_x_o,
    output logic [CNT_W-1:0] cur_y_o,
    output logic             row_wrap_o,
    output logic             unit_end_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic last_x;
    logic more_rows;

    // A configured count of zero means the largest count.
    function automatic logic [CNT_W-1:0] eff_cnt(input logic [CNT_W-1:0] v);
        return (v == '0) ? '1 : v;
    endfunction

    // Classify the accepted element as mid-row, row change or unit end.
    always_comb begin
        last_x     = (cur_x_o == ONE);
        more_rows  = two_d_i && (cur_y_o > ONE);
        row_wrap_o = step_i && last_x && more_rows;
        unit_end_o = step_i && last_x && !more_rows;
    end

    // Counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x_o <= '0;
            cur_y_o <= '0;
        end else if (load_i) begin
            cur_x_o <= eff_cnt(ld_x_i);
            cur_y_o <= eff_cnt(ld_y_i);
        end else if (step_i) begin
            if (!last_x) begin
                cur_x_o <= cur_x_o - ONE;
            end else if (more_rows) begin
                cur_y_o <= cur_y_o - ONE;
                cur_x_o <= eff_cnt(row_x_i);
            end else begin
                cur_x_o <= '0;
            end
        end
    end
endmodule

// File: rtl/dma2d_addr_unit.sv
// Current address register. Steps by the sign-extended X stride, or by the
// Y stride on a row change (the last X step of a row is never applied).
// Assumes ADDR_W is larger than CNT_W; load_i has priority over step_i.
module dma2d_addr_unit #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic              step_i,
    input  logic              row_wrap_i,
    input  logic [CNT_W-1:0]  x_mod_i,
    input  logic [CNT_W-1:0]  y_mod_i,
    output logic [ADDR_W-1:0] cur_addr_o
);
    localparam int EXT_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] x_step;
    logic [ADDR_W-1:0] y_step;

    // Sign-extend both strides to the address width.
    always_comb begin
        x_step = {{EXT_W{x_mod_i[CNT_W-1]}}, x_mod_i};
        y_step = {{EXT_W{y_mod_i[CNT_W-1]}}, y_mod_i};
    end

    // Address update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_o <= '0;
        end else if (load_i) begin
            cur_addr_o <= ld_addr_i;
        end else if (step_i) begin
            cur_addr_o <= cur_addr_o + (row_wrap_i ? y_step : x_step);
        end
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
// Two-dimensional DMA address generator: per-element address and count
// engine with end-of-row and end-of-unit handling, interrupt pulse and
// run/done status. Assumes elem_ack_i refers to the address on cur_addr_o.
module dma2d_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] cfg_start_addr_i,
    input  logic [CNT_W-1:0]  cfg_x_count_i,
    input  logic [CNT_W-1:0]  cfg_x_mod_i,
    input  logic [CNT_W-1:0]  cfg_y_count_i,
    input  logic [CNT_W-1:0]  cfg_y_mod_i,
    input  logic              cfg_2d_i,
    input  logic              cfg_irq_en_i,
    input  logic              cfg_row_irq_i,
    input  logic [1:0]        cfg_flow_i,
    input  logic              elem_ack_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  cur_x_o,
    output logic [CNT_W-1:0]  cur_y_o,
    output logic              run_o,
    output logic              done_o,
    output logic              irq_o,
    output logic              desc_req_o
);
    import dma2d_pkg::*;

    logic [ADDR_W-1:0] lat_start_addr;
    logic [CNT_W-1:0]  lat_x_count, lat_x_mod, lat_y_count, lat_y_mod;
    logic              lat_2d, lat_irq_en, lat_row_irq;
    logic [1:0]        lat_flow_raw;
    flow_e             lat_flow;

    logic              accept, step, load, row_wrap, unit_end;
    logic              end_auto, end_desc, end_stop;
    logic [ADDR_W-1:0] ld_addr;
    logic [CNT_W-1:0]  ld_x, ld_y;

    dma2d_cfg_latch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .capture_i(start_i),
        .start_addr_i(cfg_start_addr_i), .x_count_i(cfg_x_count_i),
        .x_mod_i(cfg_x_mod_i), .y_count_i(cfg_y_count_i),
        .y_mod_i(cfg_y_mod_i), .two_d_i(cfg_2d_i), .irq_en_i(cfg_irq_en_i),
        .row_irq_i(cfg_row_irq_i), .flow_i(cfg_flow_i),
        .start_addr_o(lat_start_addr), .x_count_o(lat_x_count),
        .x_mod_o(lat_x_mod), .y_count_o(lat_y_count), .y_mod_o(lat_y_mod),
        .two_d_o(lat_2d), .irq_en_o(lat_irq_en), .row_irq_o(lat_row_irq),
        .flow_o(lat_flow_raw)
    );

    // Decode the end-of-unit action and the reload sources.
    always_comb begin
        lat_flow = flow_e'(lat_flow_raw);
        accept   = elem_ack_i && run_o && (cur_x_o != '0);
        step     = accept && !start_i;
        end_auto = unit_end && (lat_flow == FLOW_AUTO);
        end_desc = unit_end && (lat_flow == FLOW_DESC);
        end_stop = unit_end && (lat_flow == FLOW_STOP || lat_flow == FLOW_RSVD);
        load     = start_i || end_auto;
        ld_addr  = start_i ? cfg_start_addr_i : lat_start_addr;
        ld_x     = start_i ? cfg_x_count_i : lat_x_count;
        ld_y     = start_i ? cfg_y_count_i : lat_y_count;
    end

    dma2d_count_unit #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(load), .ld_x_i(ld_x), .ld_y_i(ld_y),
        .step_i(step), .row_x_i(lat_x_count), .two_d_i(lat_2d),
        .cur_x_o(cur_x_o), .cur_y_o(cur_y_o),
        .row_wrap_o(row_wrap), .unit_end_o(unit_end)
    );

    dma2d_addr_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_i(load), .ld_addr_i(ld_addr),
        .step_i(step), .row_wrap_i(row_wrap), .x_mod_i(lat_x_mod),
        .y_mod_i(lat_y_mod), .cur_addr_o(cur_addr_o)
    );

    // Run/done status and the one-cycle irq and descriptor pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o      <= 1'b0;
            done_o     <= 1'b0;
            irq_o      <= 1'b0;
            desc_req_o <= 1'b0;
        end else begin
            irq_o      <= lat_irq_en && (unit_end || (row_wrap && lat_row_irq));
            desc_req_o <= end_desc;
            if (start_i) begin
                run_o  <= 1'b1;
                done_o <= 1'b0;
                irq_o  <= 1'b0;
            end else if (end_stop) begin
                run_o  <= 1'b0;
                done_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
// Property checker for the 2D DMA address generator, bound to the top.
module dma2d_addr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              elem_ack_i,
    input logic [ADDR_W-1:0] cur_addr_o,
    input logic [CNT_W-1:0]  cur_x_o,
    input logic [CNT_W-1:0]  cur_y_o,
    input logic              run_o,
    input logic              done_o,
    input logic              irq_o,
    input logic              desc_req_o,
    input logic [CNT_W-1:0]  lat_x_mod,
    input logic              lat_2d
);
    localparam int EXT_W = ADDR_W - CNT_W;

    // R4: idle element acks change nothing.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !start_i) |=> ($stable(cur_addr_o) && $stable(cur_x_o) && $stable(cur_y_o)));

    // R3: mid-row step.
    p_x_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && elem_ack_i && !start_i && cur_x_o > CNT_W'(1)) |=>
        (cur_x_o == $past(cur_x_o) - CNT_W'(1) &&
         cur_addr_o == $past(cur_addr_o) + {{EXT_W{$past(lat_x_mod[CNT_W-1])}}, $past(lat_x_mod)}));

    // R5: row change decrements Y.
    p_row_y_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && elem_ack_i && !start_i && cur_x_o == CNT_W'(1) && lat_2d && cur_y_o > CNT_W'(1))
        |=> (cur_y_o == $past(cur_y_o) - CNT_W'(1)));

    // R6: irq only follows an accepted element.
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(elem_ack_i && run_o));

    // R8: done and run are never both set.
    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !run_o);

    // R10: a descriptor request leaves the channel running with X at zero.
    p_desc_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req_o |-> (run_o && cur_x_o == '0));

    // R2: start sets run.
    p_start_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (run_o && !done_o));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .elem_ack_i(elem_ack_i),
    .cur_addr_o(cur_addr_o), .cur_x_o(cur_x_o), .cur_y_o(cur_y_o),
    .run_o(run_o), .done_o(done_o), .irq_o(irq_o), .desc_req_o(desc_req_o),
    .lat_x_mod(lat_x_mod), .lat_2d(lat_2d)
);

// File: tb/dma2d_addr_gen_tb.sv
// Bench: behavioural reference model compared with the design every clock.
module dma2d_addr_gen_tb;
    localparam int AW = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] c_addr = '0;
    logic [CW-1:0] c_x = '0, c_xm = '0, c_y = '0, c_ym = '0;
    logic c_2d = 1'b0, c_ien = 1'b0, c_rirq = 1'b0;
    logic [1:0] c_flow = 2'b00;
    logic ack = 1'b0;

    logic [AW-1:0] d_addr;
    logic [CW-1:0] d_x, d_y;
    logic d_run, d_done, d_irq, d_desc;

    always #2 clk = ~clk;

    dma2d_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_start_addr_i(c_addr),
        .cfg_x_count_i(c_x), .cfg_x_mod_i(c_xm), .cfg_y_count_i(c_y),
        .cfg_y_mod_i(c_ym), .cfg_2d_i(c_2d), .cfg_irq_en_i(c_ien),
        .cfg_row_irq_i(c_rirq), .cfg_flow_i(c_flow), .elem_ack_i(ack),
        .cur_addr_o(d_addr), .cur_x_o(d_x), .cur_y_o(d_y), .run_o(d_run),
        .done_o(d_done), .irq_o(d_irq), .desc_req_o(d_desc)
    );

    // Reference model state.
    longint m_addr;
    int m_x, m_y;
    bit m_run, m_done, m_irq, m_desc;
    longint l_addr;
    int l_x, l_y, l_xm, l_ym, l_flow;
    bit l_2d, l_ien, l_rirq;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";

    function automatic int eff(input int v);
        return (v == 0) ? 65535 : v;
    endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_x = 0; m_y = 0;
            m_run = 0; m_done = 0; m_irq = 0; m_desc = 0;
        end else if (start) begin
            l_addr = c_addr; l_x = c_x; l_y = c_y;
            l_xm = int'($signed(c_xm)); l_ym = int'($signed(c_ym));
            l_2d = c_2d; l_ien = c_ien; l_rirq = c_rirq; l_flow = c_flow;
            m_addr = l_addr; m_x = eff(l_x); m_y = eff(l_y);
            m_run = 1; m_done = 0; m_irq = 0; m_desc = 0;
        end else begin
            m_irq = 0; m_desc = 0;
            if (m_run && ack && m_x != 0) begin
                if (m_x > 1) begin
                    m_addr = m_addr + l_xm; m_x = m_x - 1;
                end else if (l_2d && m_y > 1) begin
                    m_y = m_y - 1; m_x = eff(l_x);
                    m_addr = m_addr + l_ym;
                    m_irq = l_ien && l_rirq;
                end else begin
                    m_irq = l_ien;
                    if (l_flow == 1) begin
                        m_addr = l_addr; m_x = eff(l_x); m_y = eff(l_y);
                    end else begin
                        m_addr = m_addr + l_xm; m_x = 0;
                        if (l_flow == 2) m_desc = 1;
                        else begin m_run = 0; m_done = 1; end
                    end
                end
            end
            m_addr = m_addr & 64'hFFFF_FFFF;
        end
    end

    task automatic compare();
        n_cmp++;
        if (d_addr !== AW'(m_addr) || d_x !== CW'(m_x) || d_y !== CW'(m_y) ||
            d_run !== m_run || d_done !== m_done || d_irq !== m_irq || d_desc !== m_desc) begin
            n_bad++;
            $display("FAIL %s: actual addr=%h x=%0d y=%0d run=%b done=%b irq=%b desc=%b expected addr=%h x=%0d y=%0d run=%b done=%b irq=%b desc=%b",
                     tag, d_addr, d_x, d_y, d_run, d_done, d_irq, d_desc,
                     AW'(m_addr), m_x, m_y, m_run, m_done, m_irq, m_desc);
        end
    endtask

    task automatic tick(input logic a);
        ack = a;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic kick(input logic [AW-1:0] a, input int x, input int xm,
                        input int y, input int ym, input logic d2,
                        input logic ie, input logic ri, input logic [1:0] fl,
                        input logic a_in);
        c_addr = a; c_x = CW'(x); c_xm = CW'(xm); c_y = CW'(y); c_ym = CW'(ym);
        c_2d = d2; c_ien = ie; c_rirq = ri; c_flow = fl;
        start = 1'b1;
        tick(a_in);
        start = 1'b0;
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick(1'b0);
        rst_n = 1'b1;
        tag = "R1"; tick(1'b0);
        // R4: acks before any start are ignored
        tag = "R4"; repeat (3) tick(1'b1);
        // R2, R3, R6, R8: 1D stop mode with irq
        tag = "R2"; kick(32'h1000, 4, 4, 1, 0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1);
        tag = "R3"; tick(1'b1); tick(1'b0); tick(1'b1); tick(1'b1);
        tag = "R6"; tick(1'b1);
        tag = "R8"; tick(1'b0);
        tag = "R4"; repeat (3) tick(1'b1);
        // R5, R7, R9: 2D autobuffer with row interrupts
        tag = "R5"; kick(32'h2000, 3, 2, 3, 16, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0);
        for (int i = 0; i < 9; i++) begin
            tag = (i % 3 == 2) ? "R7" : "R5";
            tick(1'b1); tick(1'b0);
        end
        tag = "R9"; repeat (4) tick(1'b1);
        // R3, R10: negative stride, descriptor mode
        tag = "R3"; kick(32'h3000, 3, -4, 0, 0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0);
        tick(1'b1); tick(1'b1);
        tag = "R10"; tick(1'b1); repeat (3) tick(1'b1);
        // R2: restart while running, zero count, start beats ack
        tag = "R2"; kick(32'h4000, 0, 1, 2, 0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1);
        tick(1'b1);
        tag = "R8"; kick(32'h5000, 1, 8, 1, 0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0);
        tick(1'b1); tick(1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule